// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block holds two independent 32-bit down counters behind one register window. Each counter can run periodically, reloading itself every time it expires, or run once and then halt. Software sets a reload value, starts a counter through its control register and is told of each expiry through a sticky status bit. It can let that bit drive the counter's own interrupt line. A separate shadow reload register changes the period of a running counter from the next reload onward, so the count in progress is not disturbed.

The counters advance on a shared clock-enable pulse, `tick_i`, not on every clock. Each counter is a two-state machine. **STOPPED** holds the count. **RUNNING** takes one off the count on each tick. The transitions are named as follows. *Start* (STOPPED→RUNNING, or RUNNING→RUNNING as a restart) happens on a control write with the enable bit set, or on a reload write while that bit is set. *Halt* (RUNNING→STOPPED) happens on a control write with the enable bit clear. *Expire-reload* (RUNNING→RUNNING) is a tick at a count of 1 or 0 in periodic mode. *Expire-halt* (RUNNING→STOPPED) is a tick at a count of 1 or 0 in one-shot mode.

Access goes through a simple synchronous port. It takes a byte address, a write flag and full 32-bit words. Read data is registered.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, every register of both timers reads 0, both counters are stopped and both interrupt lines are low.
- R2: The word address is the byte address shifted right by 2. Words 0 to 5 map to timer 0 and words 6 to 11 map to timer 1. Within a timer the offsets are: 0 count, 1 reload, 2 shadow reload, 3 control, 4 raw status, 5 masked status. Words 12 and above read 0, and writes to them change nothing.
- R3: Control bit 0 is enable, bit 1 is one-shot (0 means periodic) and bit 2 is interrupt enable. The control register reads back those three bits, with all higher bits reading 0.
- R4: A control write with bit 0 set loads the count from the reload register and enters RUNNING, even if the counter is already running. A control write with bit 0 clear enters STOPPED and keeps the count. A register write in the same cycle as a tick takes priority over the tick.
- R5: In RUNNING, each tick with a count above 1 lowers the count by exactly 1. In STOPPED the count never changes.
- R6: A tick in RUNNING at a count of 1 or 0 is an expiry, and it sets raw status bit 0. In periodic mode the count reloads from the reload register and the counter keeps running. A reload value L therefore gives one expiry every max(L,1) ticks.
- R7: In one-shot mode an expiry sets the count to 0 and enters STOPPED.
- R8: A reload write while control bit 0 is set puts the new value into the count at once and the counter runs from it. While control bit 0 is clear, a reload write only stores the value.
- R9: A shadow reload write stores the value in both the shadow and the reload register. The count in progress is left alone, and the new value is used at the next periodic reload.
- R10: Writing 1 to raw status bit 0 clears it, and writing 0 leaves it unchanged. If an expiry happens in the same cycle as a clear, the bit stays set.
- R11: Each interrupt line equals raw status bit 0 AND control bit 2 of its timer. The masked status register reads that same value in bit 0.
- R12: Writes to the count and masked status offsets are ignored. A count read returns the live count.
- R13: Read data appears on `bus_rdata_o` in the cycle after a read request and holds until the next read request.
- R14: The two timers are independent. Accesses and ticks seen by one timer leave the other timer's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable pulse shared by both timers |
| bus_sel_i | input | 1 | Access request |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 2 | Interrupt line per timer |

## Verification
The expiry and stop properties assume that a cycle carrying a write to a timer is excluded from that timer's tick behaviour, because writes take priority. They are therefore qualified by "no write to this channel". The properties also take `tick_i` to be a clean single-cycle enable with no meaning beyond that. The bench drives accesses and ticks only on falling edges, holds every request for exactly one cycle, and starts ticks only after the access that configures a timer has finished. The single exception is the deliberate clear-during-expiry cycle, which is covered by its own property condition.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } tmr_state_e;

    localparam int unsigned REGS_PER_TMR = 6;

    localparam logic [2:0] OFF_COUNT  = 3'd0;
    localparam logic [2:0] OFF_RELOAD = 3'd1;
    localparam logic [2:0] OFF_SHADOW = 3'd2;
    localparam logic [2:0] OFF_CTRL   = 3'd3;
    localparam logic [2:0] OFF_RAW    = 3'd4;
    localparam logic [2:0] OFF_MASKED = 3'd5;

    localparam int unsigned CB_EN  = 0;
    localparam int unsigned CB_ONE = 1;
    localparam int unsigned CB_IE  = 2;
    localparam int unsigned CTRL_W = 3;

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
    import tmr_pkg::*;
#(
    parameter int unsigned WW   = 6,
    parameter int unsigned NTMR = 2,
    parameter int unsigned TW   = 1
) (
    input  logic [WW-1:0] word_i,
    output logic          hit_o,
    output logic [TW-1:0] tsel_o,
    output logic [2:0]    off_o
);

    always_comb begin
        hit_o  = 1'b0;
        tsel_o = '0;
        off_o  = '0;
        for (int i = 0; i < int'(NTMR); i++) begin
            if (!hit_o
                && int'(word_i) >= i * int'(REGS_PER_TMR)
                && int'(word_i) < (i + 1) * int'(REGS_PER_TMR)) begin
                hit_o  = 1'b1;
                tsel_o = TW'(i);
                off_o  = 3'(int'(word_i) - i * int'(REGS_PER_TMR));
            end
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [2:0]        off_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     count_o,
    output logic [DW-1:0]     reload_o,
    output logic [DW-1:0]     shadow_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              raw_o,
    output logic              running_o,
    output logic              irq_o
);

    tmr_state_e        state_q, state_d;
    logic [DW-1:0]     cnt_q, cnt_d;
    logic [DW-1:0]     rel_q, rel_d;
    logic [DW-1:0]     shd_q, shd_d;
    logic [CTRL_W-1:0] ctl_q, ctl_d;
    logic              raw_q, raw_d;
    logic              expire;

    // state register process
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_STOPPED;
            cnt_q   <= '0;
            rel_q   <= '0;
            shd_q   <= '0;
            ctl_q   <= '0;
            raw_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            rel_q   <= rel_d;
            shd_q   <= shd_d;
            ctl_q   <= ctl_d;
            raw_q   <= raw_d;
        end
    end

    // next-state process: counting transitions, then register writes on top
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rel_d   = rel_q;
        shd_d   = shd_q;
        ctl_d   = ctl_q;
        raw_d   = raw_q;
        expire  = 1'b0;

        unique case (state_q)
            ST_STOPPED: begin
                cnt_d = cnt_q;
            end
            ST_RUNNING: begin
                if (tick_i) begin
                    if (cnt_q <= DW'(1)) begin
                        expire = 1'b1;
                        if (ctl_q[CB_ONE]) begin
                            cnt_d   = '0;            // expire-halt
                            state_d = ST_STOPPED;
                        end else begin
                            cnt_d   = rel_q;         // expire-reload
                        end
                    end else begin
                        cnt_d = cnt_q - DW'(1);
                    end
                end
            end
        endcase

        if (expire) begin
            raw_d = 1'b1;
        end

        if (wr_i) begin
            case (off_i)
                OFF_RELOAD: begin
                    rel_d = wdata_i;
                    if (ctl_q[CB_EN]) begin
                        cnt_d   = wdata_i;
                        state_d = ST_RUNNING;
                    end
                end
                OFF_SHADOW: begin
                    shd_d = wdata_i;
                    rel_d = wdata_i;
                end
                OFF_CTRL: begin
                    ctl_d = wdata_i[CTRL_W-1:0];
                    if (wdata_i[CB_EN]) begin
                        cnt_d   = rel_q;             // start / restart
                        state_d = ST_RUNNING;
                    end else begin
                        cnt_d   = cnt_q;             // halt
                        state_d = ST_STOPPED;
                    end
                end
                OFF_RAW: begin
                    if (wdata_i[0] && !expire) begin
                        raw_d = 1'b0;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // output process
    always_comb begin
        count_o   = cnt_q;
        reload_o  = rel_q;
        shadow_o  = shd_q;
        ctrl_o    = ctl_q;
        raw_o     = raw_q;
        running_o = (state_q == ST_RUNNING);
        irq_o     = raw_q & ctl_q[CB_IE];
    end

endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
    import tmr_pkg::*;
#(
    parameter int unsigned DW   = 32,
    parameter int unsigned AW   = 8,
    parameter int unsigned NTMR = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_i,
    input  logic            bus_sel_i,
    input  logic            bus_wr_i,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic [DW-1:0]   bus_wdata_i,
    output logic [DW-1:0]   bus_rdata_o,
    output logic [NTMR-1:0] irq_o
);

    localparam int unsigned WW = AW - 2;
    localparam int unsigned TW = (NTMR > 1) ? $clog2(NTMR) : 1;

    logic                             dec_hit;
    logic [TW-1:0]                    dec_tsel;
    logic [2:0]                       dec_off;
    logic [NTMR-1:0]                  wr_ch;
    logic [NTMR-1:0][DW-1:0]          cnt_a;
    logic [NTMR-1:0][DW-1:0]          rel_a;
    logic [NTMR-1:0][DW-1:0]          shd_a;
    logic [NTMR-1:0][CTRL_W-1:0]      ctl_a;
    logic [NTMR-1:0]                  raw_a;
    logic [NTMR-1:0]                  run_a;
    logic [DW-1:0]                    rd_val;
    logic [DW-1:0]                    rdata_q;
    logic                             unused_lsb;

    assign unused_lsb = ^bus_addr_i[1:0];

    tmr_addr_dec #(
        .WW   (WW),
        .NTMR (NTMR),
        .TW   (TW)
    ) u_dec (
        .word_i (bus_addr_i[AW-1:2]),
        .hit_o  (dec_hit),
        .tsel_o (dec_tsel),
        .off_o  (dec_off)
    );

    for (genvar gi = 0; gi < int'(NTMR); gi++) begin : g_ch
        assign wr_ch[gi] = bus_sel_i && bus_wr_i && dec_hit && (dec_tsel == TW'(gi));

        tmr_channel #(
            .DW (DW)
        ) u_ch (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .tick_i    (tick_i),
            .wr_i      (wr_ch[gi]),
            .off_i     (dec_off),
            .wdata_i   (bus_wdata_i),
            .count_o   (cnt_a[gi]),
            .reload_o  (rel_a[gi]),
            .shadow_o  (shd_a[gi]),
            .ctrl_o    (ctl_a[gi]),
            .raw_o     (raw_a[gi]),
            .running_o (run_a[gi]),
            .irq_o     (irq_o[gi])
        );
    end

    always_comb begin
        rd_val = '0;
        if (dec_hit) begin
            case (dec_off)
                OFF_COUNT:  rd_val = cnt_a[dec_tsel];
                OFF_RELOAD: rd_val = rel_a[dec_tsel];
                OFF_SHADOW: rd_val = shd_a[dec_tsel];
                OFF_CTRL:   rd_val = {{(DW-CTRL_W){1'b0}}, ctl_a[dec_tsel]};
                OFF_RAW:    rd_val = {{(DW-1){1'b0}}, raw_a[dec_tsel]};
                OFF_MASKED: rd_val = {{(DW-1){1'b0}}, irq_o[dec_tsel]};
                default:    rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else if (bus_sel_i && !bus_wr_i) begin
            rdata_q <= rd_val;
        end
    end

    assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int unsigned DW   = 32,
    parameter int unsigned NTMR = 2
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        tick_i,
    input logic [NTMR-1:0]             wr_ch,
    input logic [2:0]                  dec_off,
    input logic [DW-1:0]               wdata,
    input logic [NTMR-1:0][DW-1:0]     cnt_a,
    input logic [NTMR-1:0][DW-1:0]     rel_a,
    input logic [NTMR-1:0][CTRL_W-1:0] ctl_a,
    input logic [NTMR-1:0]             raw_a,
    input logic [NTMR-1:0]             run_a,
    input logic [NTMR-1:0]             irq
);

    for (genvar gi = 0; gi < int'(NTMR); gi++) begin : g_chk
        // R5: a running count drops by one per tick
        a_r5_tick_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (run_a[gi] && tick_i && !wr_ch[gi] && cnt_a[gi] > DW'(1))
            |=> (cnt_a[gi] == $past(cnt_a[gi]) - DW'(1)));

        // R5: a stopped count is frozen without writes
        a_r5_stopped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!run_a[gi] && !wr_ch[gi]) |=> (!run_a[gi] && $stable(cnt_a[gi])));

        // R6: periodic expiry reloads and flags
        a_r6_periodic_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (run_a[gi] && tick_i && !wr_ch[gi] && cnt_a[gi] <= DW'(1) && !ctl_a[gi][CB_ONE])
            |=> (raw_a[gi] && run_a[gi] && cnt_a[gi] == $past(rel_a[gi])));

        // R7: one-shot expiry halts at zero
        a_r7_oneshot_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (run_a[gi] && tick_i && !wr_ch[gi] && cnt_a[gi] <= DW'(1) && ctl_a[gi][CB_ONE])
            |=> (raw_a[gi] && !run_a[gi] && cnt_a[gi] == '0));

        // R4: enabling control write restarts from the reload value
        a_r4_ctrl_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_ch[gi] && dec_off == OFF_CTRL && wdata[CB_EN])
            |=> (run_a[gi] && cnt_a[gi] == $past(rel_a[gi])));

        // R10: clear without a concurrent expiry drops the flag
        a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_ch[gi] && dec_off == OFF_RAW && wdata[0]
             && !(run_a[gi] && tick_i && cnt_a[gi] <= DW'(1)))
            |=> !raw_a[gi]);

        // R11: interrupt is silent while masked
        a_r11_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !ctl_a[gi][CB_IE] |-> !irq[gi]);
    end

endmodule

bind dual_down_timer tmr_checker #(
    .DW   (DW),
    .NTMR (NTMR)
) u_tmr_checker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .wr_ch   (wr_ch),
    .dec_off (dec_off),
    .wdata   (bus_wdata_i),
    .cnt_a   (cnt_a),
    .rel_a   (rel_a),
    .ctl_a   (ctl_a),
    .raw_a   (raw_a),
    .run_a   (run_a),
    .irq     (irq_o)
);

// File: tb/test_dual_down_timer.sv
module test_dual_down_timer;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dual_down_timer i_dual_down_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wrw(int word, logic [31:0] d, logic tk = 1'b0);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 8'(word * 4); wdata = d; tick = tk;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; tick = 1'b0;
    endtask

    task automatic rdw(int word, output logic [31:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = 8'(word * 4);
        @(negedge clk);
        sel = 1'b0;
        v = rdata;
    endtask

    task automatic wr_t(int t, int off, logic [31:0] d, logic tk = 1'b0);
        wrw(t * 6 + off, d, tk);
    endtask

    task automatic rd_t(int t, int off, output logic [31:0] v);
        rdw(t * 6 + off, v);
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    function automatic int exp_cnt(int l, int k, bit one);
        if (one) return (l > k) ? l - k : 0;
        return (l == 0) ? 0 : l - (k % l);
    endfunction

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int w = 0; w < 12; w++) begin
            rdw(w, v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset irq", {30'h0, irq}, 32'h0);

        // R2: out-of-window accesses and timer-1 placement
        wrw(12, 32'hFFFF_FFFF);
        wrw(63, 32'hFFFF_FFFF);
        rdw(12, v); chk("R2 word 12 reads zero", v, 32'h0);
        rdw(63, v); chk("R2 word 63 reads zero", v, 32'h0);
        wrw(7, 32'h55);
        rdw(1, v); chk("R2 timer0 reload untouched", v, 32'h0);
        rdw(7, v); chk("R2 timer1 reload at word 7", v, 32'h55);
        for (int w = 0; w < 12; w++) begin
            if (w != 7) begin
                rdw(w, v);
                chk("R2 no stray write", v, 32'h0);
            end
        end

        // R3: control readback masks upper bits
        wr_t(0, 3, 32'hFFFF_FFF8);
        rd_t(0, 3, v); chk("R3 upper control bits read 0", v, 32'h0);

        // Sweep: both timers, both modes, reloads 0..5 (R4 R5 R6 R7 R11 R14)
        for (int t = 0; t < 2; t++) begin
            for (int one = 0; one < 2; one++) begin
                for (int l = 0; l < 6; l++) begin
                    logic [31:0] cv;
                    cv = 32'h5 | (32'(one) << 1);
                    wr_t(t, 3, 32'h0);
                    wr_t(t, 4, 32'h1);
                    wr_t(t, 1, 32'(l));
                    wr_t(t, 3, cv);
                    rd_t(t, 3, v); chk("R3 control readback", v, cv);
                    for (int k = 0; k < 13; k++) begin
                        int  ec;
                        bit  er;
                        ec = exp_cnt(l, k, bit'(one));
                        er = (k >= ((l == 0) ? 1 : l));
                        rd_t(t, 0, v);
                        chk(one ? "R7 one-shot count" : "R6 periodic count", v, 32'(ec));
                        rd_t(t, 4, v);
                        chk("R6 raw status after expiry", v, {31'h0, er});
                        chk("R11 irq follows raw", {31'h0, irq[t]}, {31'h0, er});
                        ticks(1);
                    end
                end
            end
        end

        // R8: reload write while enabled restarts
        wr_t(0, 3, 32'h0);
        wr_t(0, 4, 32'h1);
        wr_t(0, 1, 32'd10);
        wr_t(0, 3, 32'h1);
        ticks(3);
        rd_t(0, 0, v); chk("R5 count after 3 ticks", v, 32'd7);
        wr_t(0, 1, 32'd4);
        rd_t(0, 0, v); chk("R8 reload write restarts", v, 32'd4);
        ticks(1);
        rd_t(0, 0, v); chk("R5 decrement after restart", v, 32'd3);

        // R9: shadow reload leaves count, used at next reload
        wr_t(0, 2, 32'd6);
        rd_t(0, 0, v); chk("R9 count kept", v, 32'd3);
        rd_t(0, 1, v); chk("R9 reload updated", v, 32'd6);
        rd_t(0, 2, v); chk("R9 shadow stored", v, 32'd6);
        ticks(3);
        rd_t(0, 0, v); chk("R9 next reload uses shadow", v, 32'd6);

        // R11: masked while interrupt enable clear
        rd_t(0, 4, v); chk("R11 raw set", v, 32'h1);
        rd_t(0, 5, v); chk("R11 masked read with ie off", v, 32'h0);
        chk("R11 irq low with ie off", {31'h0, irq[0]}, 32'h0);
        wr_t(0, 3, 32'h5);
        rd_t(0, 5, v); chk("R11 masked read with ie on", v, 32'h1);
        chk("R11 irq high with ie on", {31'h0, irq[0]}, 32'h1);
        rd_t(0, 0, v); chk("R4 restart from reload", v, 32'd6);

        // R10: write-1 clear
        wr_t(0, 4, 32'h0);
        rd_t(0, 4, v); chk("R10 write 0 keeps raw", v, 32'h1);
        wr_t(0, 4, 32'h1);
        rd_t(0, 4, v); chk("R10 write 1 clears raw", v, 32'h0);
        chk("R10 irq drops", {31'h0, irq[0]}, 32'h0);

        // R12: ignored writes
        wr_t(0, 0, 32'h1234);
        rd_t(0, 0, v); chk("R12 count write ignored", v, 32'd6);
        wr_t(0, 5, 32'h1);
        rd_t(0, 5, v); chk("R12 masked write ignored", v, 32'h0);
        rd_t(0, 4, v); chk("R12 raw untouched", v, 32'h0);

        // R4: halt keeps the count
        wr_t(0, 3, 32'h0);
        ticks(3);
        rd_t(0, 0, v); chk("R4 halted count frozen", v, 32'd6);

        // R8: reload write while disabled only stores
        wr_t(0, 1, 32'd9);
        rd_t(0, 0, v); chk("R8 disabled reload keeps count", v, 32'd6);
        rd_t(0, 1, v); chk("R8 disabled reload stored", v, 32'd9);

        // R10: expiry wins over a same-cycle clear
        wr_t(0, 1, 32'd1);
        wr_t(0, 3, 32'h1);
        wr_t(0, 4, 32'h1);
        ticks(1);
        rd_t(0, 4, v); chk("R10 raw set by expiry", v, 32'h1);
        wr_t(0, 4, 32'h1, 1'b1);
        rd_t(0, 4, v); chk("R10 expiry beats clear", v, 32'h1);
        wr_t(0, 4, 32'h1);
        rd_t(0, 4, v); chk("R10 later clear works", v, 32'h0);

        // R14: timer 1 unaffected by timer 0 activity
        wr_t(1, 3, 32'h0);
        rd_t(1, 0, v2);
        wr_t(0, 1, 32'd20);
        wr_t(0, 3, 32'h1);
        ticks(4);
        rd_t(1, 0, v); chk("R14 timer1 count unchanged", v, v2);
        rd_t(0, 0, v); chk("R14 timer0 counted", v, 32'd16);

        // R13: read data holds between reads
        rd_t(0, 1, v);
        wr_t(0, 2, 32'hABCD);
        @(negedge clk);
        chk("R13 rdata held", rdata, 32'd20);
        chk("R13 first value", v, 32'd20);

        finish_up();
    end

endmodule